// File: doc/BRIEF.md
# Vectored Interrupt Controller with Nesting Guard

The block collects interrupt requests from eight sources and turns them into one acknowledge at a time, each with a vector index. The sources are two external inputs, three timer/event counters, a time base, a real-time clock, and one combined serial transmit/receive source. Every source has a request flag and an enable bit. A single global master enable gates all service. Software reads and writes these bits through two control words. The CPU pipeline, the return stack and the peripherals sit outside the block. The block sees only a stack-full indication from the stack.

When the controller acknowledges a request, it clears the master enable on the same clock edge. This blocks nesting by default. Requests that arrive after that edge still set their flags and wait. To allow nesting, a service routine sets the master enable again. While the stack-full input is high, nothing is acknowledged, whatever the flags and enables say.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the master enable, all enables, all flags and the acknowledge output.
- R2: Control word 0 (`wr_sel`=0) holds these bits: bit 7 is the master enable; bits 6, 5 and 4 are the enables of sources 0, 1 and 2; bits 3, 2 and 1 are the flags of sources 0, 1 and 2; bit 0 reads 0. Control word 1 (`wr_sel`=1) holds these bits: bits 9..5 are the enables of sources 7..3; bits 4..0 are the flags of sources 7..3. A write with `wr_en` high loads the selected word on the next edge, using the low bits of `wr_data`.
- R3: A high bit in `src_pulse` sets that source's flag on the next edge, whatever the master enable and the enables hold.
- R4: An acknowledge is a pulse on `ack` lasting exactly one cycle. It follows the edge at which the master enable is 1, `stack_full` is 0, and some source has both its flag and its enable set. `ack_vec` then gives the source number: external 0 is 0, external 1 is 1, timers 0..2 are 2..4, the time base is 5, the real-time clock is 6 and the serial source is 7.
- R5: When several sources are pending and enabled, the controller serves the lowest source number first.
- R6: On the edge that issues an acknowledge, the master enable and the flag of the acknowledged source are cleared. No other bit changes.
- R7: While `stack_full` is high, no acknowledge is issued. A pending request is served on the first edge after `stack_full` returns low.
- R8: After an acknowledge, software can set the master enable again. A further pending, enabled request is then acknowledged (nesting).
- R9: If a source pulses on the same edge at which its request is acknowledged, its flag stays set. A pulse also takes precedence over a software write of 0 to that flag.
- R10: With the master enable at 0, or with a source's enable at 0, that request is not acknowledged, although its flag remains set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse | input | 8 | One bit per source; a high bit raises that request |
| stack_full | input | 1 | Return stack full; withholds acknowledge |
| wr_en | input | 1 | Control word write strobe |
| wr_sel | input | 1 | Selects control word 0 or 1 |
| wr_data | input | 10 | Write data; word 0 uses bits 7..0 |
| ctl0 | output | 8 | Control word 0 read value |
| ctl1 | output | 10 | Control word 1 read value |
| ack | output | 1 | One-cycle acknowledge pulse |
| ack_vec | output | 3 | Vector index of the acknowledged source |

## Verification
Some cases are rare under random stimulus. One is a source pulsing on the exact edge at which its own request is acknowledged. Another is `stack_full` falling while a request is held, with the master enable still set. The bench reaches both with directed sequences. It first loads the master enable and the flag through control-word writes, then times the pulse or the release to the grant edge. Random traffic then mixes sparse pulses, occasional writes biased towards setting the master enable, and a frequently asserted stack-full input. Every cycle is compared against a model of the register and grant rules held in the bench.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NSRC     = 8;
  localparam int VW       = $clog2(NSRC);
  localparam int LOW_SRC  = 3;                 // sources held in word 0
  localparam int HIGH_SRC = NSRC - LOW_SRC;    // sources held in word 1
  localparam int C0W      = 8;
  localparam int C1W      = 2 * HIGH_SRC;
  localparam int DW       = (C1W > C0W) ? C1W : C0W;
  localparam int C0_MASTER   = 7;
  localparam int C0_EN_TOP   = 6;
  localparam int C0_FLAG_TOP = 3;
endpackage

// File: rtl/irqv_regs.sv
module irqv_regs
  import irqv_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [DW-1:0]   wr_data,
  input  logic [NSRC-1:0] src_pulse,
  input  logic            grant,
  input  logic [VW-1:0]   grant_id,
  output logic            master_en,
  output logic [NSRC-1:0] src_en,
  output logic [NSRC-1:0] src_flag
);
  logic            master_d;
  logic [NSRC-1:0] en_d;
  logic [NSRC-1:0] flag_d;

  always_comb begin
    master_d = master_en;
    en_d     = src_en;
    flag_d   = src_flag;
    if (wr_en) begin
      if (!wr_sel) begin
        master_d = wr_data[C0_MASTER];
        for (int k = 0; k < LOW_SRC; k++) begin
          en_d[k]   = wr_data[C0_EN_TOP - k];
          flag_d[k] = wr_data[C0_FLAG_TOP - k];
        end
      end else begin
        for (int k = 0; k < HIGH_SRC; k++) begin
          en_d[LOW_SRC + k]   = wr_data[HIGH_SRC + k];
          flag_d[LOW_SRC + k] = wr_data[k];
        end
      end
    end
    if (grant) begin
      master_d         = 1'b0;
      flag_d[grant_id] = 1'b0;
    end
    flag_d = flag_d | src_pulse;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      master_en <= 1'b0;
      src_en    <= '0;
      src_flag  <= '0;
    end else begin
      master_en <= master_d;
      src_en    <= en_d;
      src_flag  <= flag_d;
    end
  end
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio
  import irqv_pkg::*;
(
  input  logic [NSRC-1:0] req,
  output logic            any,
  output logic [VW-1:0]   id
);
  always_comb begin
    id = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) id = VW'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_pulse,
  input  logic            stack_full,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [DW-1:0]   wr_data,
  output logic [C0W-1:0]  ctl0,
  output logic [C1W-1:0]  ctl1,
  output logic            ack,
  output logic [VW-1:0]   ack_vec
);
  logic            master_en;
  logic [NSRC-1:0] src_en;
  logic [NSRC-1:0] src_flag;
  logic            any_pend;
  logic [VW-1:0]   pend_id;
  logic            grant;

  assign grant = master_en & ~stack_full & any_pend;

  irqv_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .src_pulse (src_pulse),
    .grant     (grant),
    .grant_id  (pend_id),
    .master_en (master_en),
    .src_en    (src_en),
    .src_flag  (src_flag)
  );

  irqv_prio u_prio (
    .req (src_flag & src_en),
    .any (any_pend),
    .id  (pend_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack     <= 1'b0;
      ack_vec <= '0;
    end else begin
      ack <= grant;
      if (grant) ack_vec <= pend_id;
    end
  end

  assign ctl0[C0_MASTER] = master_en;
  assign ctl0[0]         = 1'b0;
  for (genvar k = 0; k < LOW_SRC; k++) begin : g_word0
    assign ctl0[C0_EN_TOP - k]   = src_en[k];
    assign ctl0[C0_FLAG_TOP - k] = src_flag[k];
  end
  for (genvar k = 0; k < HIGH_SRC; k++) begin : g_word1
    assign ctl1[HIGH_SRC + k] = src_en[LOW_SRC + k];
    assign ctl1[k]            = src_flag[LOW_SRC + k];
  end
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker (
  input logic       clk,
  input logic       rst,
  input logic [7:0] src_pulse,
  input logic       stack_full,
  input logic [7:1] c0,
  input logic [9:0] c1,
  input logic       ack,
  input logic [2:0] ack_vec
);
  logic [7:0] flags, ens, pend, pend_prev;
  assign flags = {c1[4:0], c0[1], c0[2], c0[3]};
  assign ens   = {c1[9:5], c0[4], c0[5], c0[6]};
  assign pend  = flags & ens;

  always_ff @(posedge clk) begin
    if (rst) pend_prev <= '0;
    else     pend_prev <= pend;
  end

  a_r4_ack_one_cycle: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
  a_r10_ack_needs_master: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(c0[7]));
  a_r7_no_ack_when_full: assert property (@(posedge clk) disable iff (rst)
    ack |-> !$past(stack_full));
  a_r6_master_cleared: assert property (@(posedge clk) disable iff (rst)
    ack |-> !c0[7]);
  a_r4_vec_was_pending: assert property (@(posedge clk) disable iff (rst)
    ack |-> pend_prev[ack_vec]);
  a_r5_lowest_first: assert property (@(posedge clk) disable iff (rst)
    ack |-> ((pend_prev & ((8'd1 << ack_vec) - 8'd1)) == 8'd0));

  for (genvar i = 0; i < 8; i++) begin : g_pulse
    a_r3_pulse_latches: assert property (@(posedge clk) disable iff (rst)
      src_pulse[i] |=> flags[i]);
  end
endmodule

bind irq_vector_ctrl irqv_checker u_irqv_checker (
  .clk        (clk),
  .rst        (rst),
  .src_pulse  (src_pulse),
  .stack_full (stack_full),
  .c0         (ctl0[7:1]),
  .c1         (ctl1),
  .ack        (ack),
  .ack_vec    (ack_vec)
);

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] src_pulse;
  logic       stack_full;
  logic       wr_en;
  logic       wr_sel;
  logic [9:0] wr_data;
  logic [7:0] ctl0;
  logic [9:0] ctl1;
  logic       ack;
  logic [2:0] ack_vec;

  always #2.5 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst(rst), .src_pulse(src_pulse), .stack_full(stack_full),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctl0(ctl0), .ctl1(ctl1), .ack(ack), .ack_vec(ack_vec)
  );

  int checks = 0;
  int errors = 0;

  logic       m_master;
  logic [7:0] m_en, m_flag;
  logic       m_ack;
  int         m_vec;

  function automatic logic [7:0] exp_c0();
    return {m_master, m_en[0], m_en[1], m_en[2], m_flag[0], m_flag[1], m_flag[2], 1'b0};
  endfunction

  function automatic logic [9:0] exp_c1();
    return {m_en[7], m_en[6], m_en[5], m_en[4], m_en[3],
            m_flag[7], m_flag[6], m_flag[5], m_flag[4], m_flag[3]};
  endfunction

  function automatic int lowest(input logic [7:0] p);
    for (int i = 0; i < 8; i++) if (p[i]) return i;
    return 0;
  endfunction

  task automatic model_edge();
    logic [7:0] pend, nflag, nen;
    logic       nmaster, grant;
    int         s;
    if (rst) begin
      m_master = 0; m_en = '0; m_flag = '0; m_ack = 0; m_vec = 0;
      return;
    end
    pend  = m_flag & m_en;
    grant = m_master && !stack_full && (pend != 0);
    s     = lowest(pend);
    nmaster = m_master; nen = m_en; nflag = m_flag;
    if (wr_en) begin
      if (!wr_sel) begin
        nmaster = wr_data[7];
        nen[0] = wr_data[6]; nen[1] = wr_data[5]; nen[2] = wr_data[4];
        nflag[0] = wr_data[3]; nflag[1] = wr_data[2]; nflag[2] = wr_data[1];
      end else begin
        for (int k = 0; k < 5; k++) begin
          nen[3+k]   = wr_data[5+k];
          nflag[3+k] = wr_data[k];
        end
      end
    end
    if (grant) begin
      nmaster  = 0;
      nflag[s] = 0;
      m_vec    = s;
    end
    nflag = nflag | src_pulse;
    m_master = nmaster; m_en = nen; m_flag = nflag; m_ack = grant;
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, "ctl0", int'(ctl0), int'(exp_c0()));
    chk(tag, "ctl1", int'(ctl1), int'(exp_c1()));
    chk(tag, "ack", int'(ack), int'(m_ack));
    if (m_ack) chk(tag, "ack_vec", int'(ack_vec), m_vec);
    src_pulse = '0;
    wr_en = 0;
  endtask

  task automatic wr(input logic sel, input logic [9:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; src_pulse = '0; stack_full = 0; wr_en = 0; wr_sel = 0; wr_data = '0;
    m_master = 0; m_en = '0; m_flag = '0; m_ack = 0; m_vec = 0;
    @(negedge clk);
    step("R1"); step("R1");
    chk("R1", "ctl0 literal", int'(ctl0), 0);
    chk("R1", "ctl1 literal", int'(ctl1), 0);
    chk("R1", "ack literal", int'(ack), 0);
    rst = 0;

    wr(1, 10'h3E0); step("R2");
    chk("R2", "ctl1 enables", int'(ctl1), 'h3E0);
    wr(0, 10'h070); step("R2");
    chk("R2", "ctl0 enables", int'(ctl0), 'h70);

    src_pulse = 8'h20; step("R3");
    chk("R3", "flag5 latched", int'(ctl1), 'h3E4);
    chk("R10", "no ack master off", int'(ack), 0);
    step("R10");
    chk("R10", "still no ack", int'(ack), 0);

    wr(0, 10'h0F0); step("R2");
    chk("R2", "master set", int'(ctl0), 'hF0);
    step("R4");
    chk("R4", "ack", int'(ack), 1);
    chk("R4", "vec 5", int'(ack_vec), 5);
    chk("R6", "master cleared", int'(ctl0), 'h70);
    chk("R6", "flag5 cleared", int'(ctl1), 'h3E0);
    step("R4");
    chk("R4", "ack one cycle", int'(ack), 0);

    src_pulse = 8'h44; step("R5");
    wr(0, 10'h0F2); step("R5");
    step("R5");
    chk("R5", "lowest first", int'(ack_vec), 2);
    chk("R5", "flag6 kept", int'(ctl1), 'h3E8);

    wr(0, 10'h0F0); step("R8");
    step("R8");
    chk("R8", "nested ack", int'(ack), 1);
    chk("R8", "nested vec", int'(ack_vec), 6);

    src_pulse = 8'h01; step("R7");
    stack_full = 1; wr(0, 10'h0F8); step("R7");
    step("R7");
    chk("R7", "held while full", int'(ack), 0);
    step("R7");
    chk("R7", "still held", int'(ack), 0);
    stack_full = 0; step("R7");
    chk("R7", "ack after release", int'(ack), 1);
    chk("R7", "vec 0", int'(ack_vec), 0);

    src_pulse = 8'h02; step("R9");
    wr(0, 10'h0F4); step("R9");
    src_pulse = 8'h02; step("R9");
    chk("R9", "ack vec 1", int'(ack_vec), 1);
    chk("R9", "flag1 survives", int'(ctl0), 'h74);
    wr(0, 10'h070); src_pulse = 8'h01; step("R9");
    chk("R9", "pulse beats write", int'(ctl0), 'h78);

    wr(0, 10'h0F0); step("R10");
    wr(1, 10'h3A0); step("R10");
    src_pulse = 8'h10; step("R10");
    chk("R10", "flag4 set", int'(ctl1), 'h3A2);
    step("R10");
    chk("R10", "disabled source ignored", int'(ack), 0);

    for (int n = 0; n < 3000; n++) begin
      src_pulse  = 8'($urandom & $urandom & $urandom);
      stack_full = ($urandom % 4) == 0;
      if (($urandom % 8) == 0) begin
        wr_en   = 1;
        wr_sel  = $urandom % 2;
        wr_data = 10'($urandom);
        if (!wr_sel && ($urandom % 4) != 0) wr_data[7] = 1'b1;
      end
      step("R4");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule